// File: doc/BRIEF.md
# Windowed Text-Mode Video Renderer

This block turns a pixel clock into a complete 640x480 video raster at about 60 Hz. It scans 800 pixels by 525 lines and drives active-low horizontal and vertical sync pulses. Every pixel outside the visible area, including the porches and sync intervals, is forced to black. The block paints a 32-column by 16-row grid of characters in a 512x384 window centred in the picture, and the border around that window is black.

The character codes sit in a single 512-entry byte memory, one byte per cell. A host writes this memory through a plain address/data/enable port, and a write may arrive in any cycle. The glyph shapes are 8x12 pixels for 128 codes. They are computed rather than stored, and each glyph is drawn at double size, so one cell covers 16x24 pixels. Glyph pixels that are set use a fixed foreground colour and clear ones use a fixed background colour. Each channel is two bits wide.

The scan counters, the cell counters and the glyph fetch run as a three-stage pipeline. Sync and blanking travel through the same stages, so every output pin describes the same raster position.

Top module: `textVgaRenderer`

## Requirements
- R1: A line is 800 pixel clocks long, numbered 0 to 799. hSyncN is low exactly on pixels 656 to 751 (96 pixels) and high on all other pixels.
- R2: A frame is 525 lines, numbered 0 to 524. vSyncN is low for the whole of lines 490 and 491 and high on all other lines.
- R3: Every pixel with a column of 640 or more, or a line of 480 or more, drives red, green and blue as 0.
- R4: Every visible pixel outside the window drives black. The window covers columns 64 to 575 and lines 48 to 431.
- R5: Inside the window, the cell column is (x-64)/16 and the cell row is (y-48)/24. The character is read from memory address row*32 + column.
- R6: Within a cell, the glyph column is ((x-64) mod 16)/2 and the glyph row is ((y-48) mod 24)/2. The pixel is bit (7 - glyph column) of the glyph row byte, so glyph column 0 is the MSB. For codes 0 to 127, glyph rows 0 and 11 are 0x00. Any other row r has the byte ({code[6:0],1} XOR {r[3:0],r[3:0]}).
- R7: A set glyph pixel drives the foreground colour {red,green,blue} = {3,3,1}. A clear glyph pixel drives the background colour {0,0,2}.
- R8: A character code with bit 7 set has no glyph, so its whole cell shows the background colour.
- R9: While rstN is low, hSyncN and vSyncN are high and the colour outputs are 0. The outputs after the N-th rising edge following reset release describe scan pixel N-3, where pixel 0 is column 0 of line 0. All output pins line up on the same pixel.
- R10: A host write (wrEn high at a rising edge) stores wrData at wrAddr. Later fetches of that cell see the new code. Writes in any cycle leave the sync timing unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock (about 25.2 MHz) |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write enable for the character memory |
| wrAddr | input | 9 | Host write cell address (row*32 + column) |
| wrData | input | 8 | Host write character code |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| red | output | 2 | Red level |
| green | output | 2 | Green level |
| blue | output | 2 | Blue level |

## Verification
The embedded assertions check several properties on every cycle:
- the counters wrap at the end of a line;
- the line counter holds steady between line ends;
- the window always lies inside the visible area;
- blanked and border pixels come out black;
- window pixels carry only the foreground or background colour;
- a sync request reaches its pin one cycle later.

Some behaviour only the bench's scenarios can show, by comparing every pixel with a behavioural raster model over more than a full frame:
- that the correct glyph bit of the correct cell lands on the correct pixel;
- that codes with bit 7 set stay blank;
- that host writes made during blanking and during active lines appear on later fetches.

// File: rtl/textVgaPkg.sv
package textVgaPkg;

  localparam int GLYPH_W   = 8;
  localparam int GLYPH_H   = 12;
  localparam int GRID_COLS = 32;
  localparam int GRID_ROWS = 16;
  localparam int CELL_AW   = $clog2(GRID_COLS * GRID_ROWS);

  // Per-pixel tag that travels down the pipeline with the fetch
  typedef struct packed {
    logic       visible;
    logic       inWindow;
    logic       hSyncAct;
    logic       vSyncAct;
    logic [2:0] glyphCol;
  } pixTag_t;

  // Strobes from the scan control to the datapath
  typedef struct packed {
    pixTag_t             tag;
    logic [3:0]          glyphRow;
    logic [CELL_AW-1:0]  charAddr;
  } scanStrobes_t;

  // Computed 8x12 font: rows 0 and 11 are empty, codes >= 128 have no glyph
  function automatic logic [7:0] glyphBits(input logic [7:0] code, input logic [3:0] row);
    if (code[7] || row == 4'd0 || row >= 4'd11) return 8'h00;
    return {code[6:0], 1'b1} ^ {row, row};
  endfunction

endpackage

// File: rtl/scanControl.sv
module scanControl
  import textVgaPkg::*;
#(
  parameter int H_VISIBLE = 640,
  parameter int H_FRONT   = 16,
  parameter int H_SYNC    = 96,
  parameter int H_BACK    = 48,
  parameter int V_VISIBLE = 480,
  parameter int V_FRONT   = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BACK    = 33,
  parameter int SCALE     = 2
) (
  input  logic         clk,
  input  logic         rstN,
  output scanStrobes_t strobes
);

  localparam int H_TOTAL = H_VISIBLE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_VISIBLE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);
  localparam int CELL_W  = GLYPH_W * SCALE;
  localparam int CELL_H  = GLYPH_H * SCALE;
  localparam int WIN_W   = GRID_COLS * CELL_W;
  localparam int WIN_H   = GRID_ROWS * CELL_H;
  localparam int SXW     = $clog2(CELL_W);
  localparam int SYW     = $clog2(CELL_H);

  localparam logic [HW-1:0] H_LAST     = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS_END  = HW'(H_VISIBLE);
  localparam logic [HW-1:0] H_SYNC_ON  = HW'(H_VISIBLE + H_FRONT);
  localparam logic [HW-1:0] H_SYNC_OFF = HW'(H_VISIBLE + H_FRONT + H_SYNC);
  localparam logic [HW-1:0] WIN_X0     = HW'((H_VISIBLE - WIN_W) / 2);
  localparam logic [HW-1:0] WIN_X1     = HW'((H_VISIBLE - WIN_W) / 2 + WIN_W);
  localparam logic [VW-1:0] V_LAST     = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_VIS_END  = VW'(V_VISIBLE);
  localparam logic [VW-1:0] V_SYNC_ON  = VW'(V_VISIBLE + V_FRONT);
  localparam logic [VW-1:0] V_SYNC_OFF = VW'(V_VISIBLE + V_FRONT + V_SYNC);
  localparam logic [VW-1:0] WIN_Y0     = VW'((V_VISIBLE - WIN_H) / 2);
  localparam logic [VW-1:0] WIN_Y1     = VW'((V_VISIBLE - WIN_H) / 2 + WIN_H);
  localparam logic [SXW-1:0] SX_LAST   = SXW'(CELL_W - 1);
  localparam logic [SYW-1:0] SY_LAST   = SYW'(CELL_H - 1);
  localparam logic [SXW-1:0] SX_DIV    = SXW'(SCALE);
  localparam logic [SYW-1:0] SY_DIV    = SYW'(SCALE);

  logic [HW-1:0]  hCount;
  logic [VW-1:0]  vCount;
  logic [SXW-1:0] subX;
  logic [SYW-1:0] subY;
  logic [4:0]     cellCol;
  logic [3:0]     cellRow;
  logic           lineEnd, inWinH, inWinV;

  assign lineEnd = (hCount == H_LAST);
  assign inWinH  = (hCount >= WIN_X0) && (hCount < WIN_X1);
  assign inWinV  = (vCount >= WIN_Y0) && (vCount < WIN_Y1);

  // Raster position counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else if (lineEnd) begin
      hCount <= '0;
      vCount <= (vCount == V_LAST) ? '0 : vCount + 1'b1;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  // Horizontal cell tracking: cleared at each line end, advances inside window
  always_ff @(posedge clk) begin
    if (!rstN || lineEnd) begin
      subX    <= '0;
      cellCol <= '0;
    end else if (inWinH) begin
      if (subX == SX_LAST) begin
        subX    <= '0;
        cellCol <= cellCol + 1'b1;
      end else begin
        subX <= subX + 1'b1;
      end
    end
  end

  // Vertical cell tracking: advances once per window line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      subY    <= '0;
      cellRow <= '0;
    end else if (lineEnd) begin
      if (vCount == V_LAST) begin
        subY    <= '0;
        cellRow <= '0;
      end else if (inWinV) begin
        if (subY == SY_LAST) begin
          subY    <= '0;
          cellRow <= cellRow + 1'b1;
        end else begin
          subY <= subY + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.tag.visible  = (hCount < H_VIS_END) && (vCount < V_VIS_END);
    strobes.tag.inWindow = inWinH && inWinV;
    strobes.tag.hSyncAct = (hCount >= H_SYNC_ON) && (hCount < H_SYNC_OFF);
    strobes.tag.vSyncAct = (vCount >= V_SYNC_ON) && (vCount < V_SYNC_OFF);
    strobes.tag.glyphCol = 3'(subX / SX_DIV);
    strobes.glyphRow     = 4'(subY / SY_DIV);
    strobes.charAddr     = {cellRow, cellCol};   // R5: row*32 + column
  end

  // R1
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hCount == H_LAST) |=> (hCount == '0));

  // R2
  v_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hCount != H_LAST) |=> $stable(vCount));

  // R4
  win_inside_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tag.inWindow |-> strobes.tag.visible);

endmodule

// File: rtl/textDatapath.sv
module textDatapath
  import textVgaPkg::*;
#(
  parameter logic [5:0] FG_COLOR = 6'b11_11_01,
  parameter logic [5:0] BG_COLOR = 6'b00_00_10
) (
  input  logic               clk,
  input  logic               rstN,
  input  scanStrobes_t       strobes,
  input  logic               wrEn,
  input  logic [CELL_AW-1:0] wrAddr,
  input  logic [7:0]         wrData,
  output logic               hSyncN,
  output logic               vSyncN,
  output logic [5:0]         rgbOut
);

  localparam int CELLS = GRID_COLS * GRID_ROWS;

  logic [7:0] charMem [CELLS];
  logic [7:0] charCode;
  logic [7:0] glyphByte;
  pixTag_t    tag1, tag2;
  logic [3:0] row1;
  logic       pixOn;

  // R10: host write port, independent of the scan
  always_ff @(posedge clk) begin
    if (wrEn) charMem[wrAddr] <= wrData;
  end

  // Stage 1: character fetch
  always_ff @(posedge clk) begin
    charCode <= charMem[strobes.charAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tag1      <= '0;
      row1      <= '0;
      tag2      <= '0;
      glyphByte <= '0;
    end else begin
      tag1      <= strobes.tag;
      row1      <= strobes.glyphRow;
      tag2      <= tag1;
      glyphByte <= glyphBits(charCode, row1);   // Stage 2: glyph row
    end
  end

  assign pixOn = glyphByte[3'd7 - tag2.glyphCol];

  // Stage 3: registered outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hSyncN <= 1'b1;
      vSyncN <= 1'b1;
      rgbOut <= '0;
    end else begin
      hSyncN <= !tag2.hSyncAct;
      vSyncN <= !tag2.vSyncAct;
      if (tag2.visible && tag2.inWindow) rgbOut <= pixOn ? FG_COLOR : BG_COLOR;
      else                               rgbOut <= '0;
    end
  end

  // R3
  blank_black_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tag2.visible |=> (rgbOut == '0));

  // R4
  border_black_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tag2.visible && !tag2.inWindow) |=> (rgbOut == '0));

  // R7
  text_color_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tag2.visible && tag2.inWindow) |=> (rgbOut == FG_COLOR || rgbOut == BG_COLOR));

  // R9
  sync_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tag2.hSyncAct || tag2.vSyncAct) |=> (!hSyncN || !vSyncN));

endmodule

// File: rtl/textVgaRenderer.sv
module textVgaRenderer
  import textVgaPkg::*;
#(
  parameter int         H_VISIBLE = 640,
  parameter int         H_FRONT   = 16,
  parameter int         H_SYNC    = 96,
  parameter int         H_BACK    = 48,
  parameter int         V_VISIBLE = 480,
  parameter int         V_FRONT   = 10,
  parameter int         V_SYNC    = 2,
  parameter int         V_BACK    = 33,
  parameter int         SCALE     = 2,
  parameter logic [5:0] FG_COLOR  = 6'b11_11_01,
  parameter logic [5:0] BG_COLOR  = 6'b00_00_10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [8:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       hSyncN,
  output logic       vSyncN,
  output logic [1:0] red,
  output logic [1:0] green,
  output logic [1:0] blue
);

  scanStrobes_t strobes;
  logic [5:0]   rgbOut;

  scanControl #(
    .H_VISIBLE(H_VISIBLE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_VISIBLE(V_VISIBLE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
    .SCALE(SCALE)
  ) ctrl (
    .clk(clk), .rstN(rstN), .strobes(strobes)
  );

  textDatapath #(
    .FG_COLOR(FG_COLOR), .BG_COLOR(BG_COLOR)
  ) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .rgbOut(rgbOut)
  );

  // R7: channel packing {red, green, blue}
  assign {red, green, blue} = rgbOut;

endmodule

// File: tb/textVgaRenderer_test.sv
module textVgaRenderer_test;

  localparam int CLK_PERIOD = 10;
  // Reduced raster so that more than a whole frame fits the run
  localparam int HV = 320, HF = 8, HS = 16, HB = 16;
  localparam int VV = 240, VF = 4, VS = 2, VB = 6;
  localparam int SC = 1;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int CW = 8 * SC, CH = 12 * SC;
  localparam int WW = 32 * CW, WH = 16 * CH;
  localparam int WX = (HV - WW) / 2, WY = (VV - WH) / 2;
  localparam logic [5:0] FG = 6'b11_11_01;
  localparam logic [5:0] BG = 6'b00_00_10;
  localparam int RUN_EDGES = HT * VT + 40 * HT;

  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [8:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       hSyncN, vSyncN;
  logic [1:0] red, green, blue;

  int  modelMem [512];
  int  edges = 0;
  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  textVgaRenderer #(
    .H_VISIBLE(HV), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_VISIBLE(VV), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .SCALE(SC), .FG_COLOR(FG), .BG_COLOR(BG)
  ) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hSyncN(hSyncN), .vSyncN(vSyncN), .red(red), .green(green), .blue(blue)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) if (rstN) edges <= edges + 1;

  // R6/R8: font rule from the requirements
  function automatic int glyphRef(int code, int row);
    if (code >= 128 || row == 0 || row >= 11) return 0;
    return (((code << 1) | 1) ^ (row * 17)) & 255;
  endfunction

  // Per-cycle comparison against the behavioural raster model (R9 latency of 3)
  always @(negedge clk) begin
    if (rstN && !done) begin
      automatic int p = edges - 3;
      automatic logic expH = 1'b1, expV = 1'b1;
      automatic logic [5:0] expC = '0;
      automatic logic [5:0] act = {red, green, blue};
      automatic string req = "R9";
      if (p >= 0) begin
        automatic int h = p % HT;
        automatic int v = (p / HT) % VT;
        expH = !(h >= HV + HF && h < HV + HF + HS);   // R1
        expV = !(v >= VV + VF && v < VV + VF + VS);   // R2
        if (!(h < HV && v < VV)) req = "R3";
        else if (!(h >= WX && h < WX + WW && v >= WY && v < WY + WH)) req = "R4";
        else begin
          automatic int cx = (h - WX) / CW, cy = (v - WY) / CH;
          automatic int code = modelMem[cy * 32 + cx];        // R5
          automatic int gr = ((v - WY) % CH) / SC;
          automatic int gc = ((h - WX) % CW) / SC;
          automatic int bits = glyphRef(code, gr);
          expC = ((bits >> (7 - gc)) & 1) ? FG : BG;          // R7
          req = "R6";
        end
      end
      checks++;
      if (hSyncN !== expH) begin
        errors++;
        $display("FAIL R1 hSyncN at pos %0d: act %b exp %b", p, hSyncN, expH);
      end else if (vSyncN !== expV) begin
        errors++;
        $display("FAIL R2 vSyncN at pos %0d: act %b exp %b", p, vSyncN, expV);
      end else if (act !== expC) begin
        errors++;
        $display("FAIL %s colour at pos %0d: act %b exp %b", req, p, act, expC);
      end
    end
  end

  // R10: host write, mirrored into the model
  task automatic hostWrite(input int addr, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 9'(addr); wrData = 8'(data);
    modelMem[addr] = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    // Fill memory during reset; the pattern includes codes with bit 7 set (R8)
    for (int i = 0; i < 512; i++) hostWrite(i, (i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    checks++;   // R9 reset state
    if (hSyncN !== 1'b1 || vSyncN !== 1'b1 || {red, green, blue} !== 6'b0) begin
      errors++;
      $display("FAIL R9 reset outputs: act %b%b%b exp 110", hSyncN, vSyncN, {red, green, blue} != 0);
    end
    rstN = 1'b1;
    // R10: write during vertical lines before the window, with bit 7 set (R8)
    wait (edges >= 5 * HT);
    hostWrite(5, 8'hC1);
    hostWrite(6, 8'h41);
    // R10: write during active lines to a cell in a later row
    wait (edges >= (WY + 2 * CH + 3) * HT + 100);
    hostWrite(10 * 32 + 7, 8'h2A);
    // R10: rewrite a row-0 cell already drawn; it shows in the next frame
    wait (edges >= (WY + 8 * CH) * HT + 40);
    hostWrite(3, 8'h7F);
    wait (edges >= RUN_EDGES);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule